// File: doc/BRIEF.md
# Sign-Magnitude Restoring Divider

This block divides one sign-magnitude integer by another. It takes several clock cycles per operation and produces one quotient bit per cycle. A one-cycle `start` strobe supplies a dividend magnitude and sign and a divisor magnitude and sign. The magnitudes go through an unsigned shift-subtract loop. Two registers hold the working state: a partial remainder, and a shift register that starts out holding the dividend and ends up holding the quotient. In each step the pair is shifted left by one place and the divisor is subtracted from the partial remainder. If the difference is negative, the old partial remainder is restored and a 0 quotient bit enters from the right. If the difference is not negative, the difference is kept and a 1 enters.

The two signs bypass the loop. The quotient sign is the exclusive OR of the operand signs, and the remainder takes the sign of the dividend. A divisor of zero skips the loop. It raises a divide-by-zero flag and returns zero magnitudes one cycle after the strobe. The result outputs are registered and keep their values until the next operation completes, and `done` marks that completion for one cycle.

Top module: `smdiv_restoring`

## Requirements
- R1: After a completion with a nonzero divisor, `quo_mag` equals floor(dividend magnitude / divisor magnitude) and `rem_mag` equals the dividend magnitude modulo the divisor magnitude (for W=4, 14 / 5 gives 2 remainder 4).
- R2: On every completion, `quo_sign` equals `dvd_sign` XOR `dvs_sign` of the accepted operands, where 1 means negative.
- R3: On every completion, `rem_sign` equals `dvd_sign` of the accepted operands.
- R4: A zero divisor magnitude makes `done` rise one clock edge after the strobe edge, with `div_zero` = 1 and `quo_mag` = `rem_mag` = 0.
- R5: A nonzero divisor makes `done` rise exactly W+1 clock edges after the strobe edge, with `div_zero` = 0.
- R6: `done` stays high for exactly one cycle per completion.
- R7: A `start` that arrives while an operation is in progress is ignored. The running operation finishes with its own operands and its own timing.
- R8: `quo_mag`, `rem_mag`, `quo_sign`, `rem_sign` and `div_zero` change only in a cycle in which `done` is high.
- R9: While reset is asserted and after reset is released, every output reads 0 until the first completion.
- R10: Boundary operands give exact results. A dividend smaller than the divisor gives quotient 0 with the remainder equal to the dividend. A zero dividend gives 0 remainder 0. A full-scale dividend divided by 1 returns the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Strobe to begin an operation; sampled only when idle |
| dvd_mag | input | W | Dividend magnitude |
| dvd_sign | input | 1 | Dividend sign (1 = negative) |
| dvs_mag | input | W | Divisor magnitude |
| dvs_sign | input | 1 | Divisor sign (1 = negative) |
| quo_mag | output | W | Quotient magnitude |
| rem_mag | output | W | Remainder magnitude |
| quo_sign | output | 1 | Quotient sign |
| rem_sign | output | 1 | Remainder sign |
| div_zero | output | 1 | Last operation had a zero divisor |
| done | output | 1 | One-cycle completion pulse |

## Verification
Most internal faults show up in a quotient or remainder that breaks the identity quotient × divisor + remainder = dividend, or in a remainder that is not smaller than the divisor. A wrong restore decision or a slipped shift corrupts every later quotient bit. Such an error is therefore visible at the first `done` after the fault, which is W+1 cycles after the strobe. A fault in the step counter or the state machine appears as a `done` that comes early, late or twice. A start accepted while busy also moves the result timing and changes the operands, so the interference test exposes it in the same operation.

// File: rtl/smdiv_pkg.sv
package smdiv_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } smdiv_state_e;

   // restore variants for the iteration step
   localparam bit RESTORE_MUX = 1'b0;
   localparam bit RESTORE_ADD = 1'b1;

endpackage

// File: rtl/smdiv_step.sv
module smdiv_step #(
   parameter int W              = 8,
   parameter bit RESTORE_BY_ADD = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] q_i,
   input  logic [W-1:0] m_i,
   output logic [W-1:0] a_o,
   output logic [W-1:0] q_o
);
   localparam int SW = W + 1;   // shifted remainder width
   localparam int DW = W + 2;   // difference width incl. sign

   logic [SW-1:0] a_sh;
   logic [DW-1:0] diff;
   logic [DW-1:0] rest;
   logic          neg;
   logic          unused_bits;

   assign a_sh = {a_i, q_i[W-1]};
   assign diff = {1'b0, a_sh} - {2'b00, m_i};
   assign neg  = diff[DW-1];

   generate
      if (RESTORE_BY_ADD) begin : g_add_back
         assign rest = diff + {2'b00, m_i};
      end else begin : g_keep_old
         assign rest = {1'b0, a_sh};
      end
   endgenerate

   assign a_o = neg ? rest[W-1:0] : diff[W-1:0];
   assign q_o = {q_i[W-2:0], ~neg};

   assign unused_bits = ^{diff[W], rest[DW-1:W]};

endmodule

// File: rtl/smdiv_ctrl.sv
module smdiv_ctrl
   import smdiv_pkg::*;
#(
   parameter int W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic dvs_zero,
   output logic busy,
   output logic load,
   output logic zfin,
   output logic last
);
   localparam int CW = $clog2(W + 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

   smdiv_state_e  state_q;
   logic [CW-1:0] cnt_q;

   assign busy = (state_q == ST_RUN);
   assign load = start && !busy && !dvs_zero;
   assign zfin = start && !busy && dvs_zero;
   assign last = busy && (cnt_q == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else if (load) begin
         state_q <= ST_RUN;
         cnt_q   <= '0;
      end else if (busy) begin
         if (last) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/smdiv_restoring.sv
module smdiv_restoring
   import smdiv_pkg::*;
#(
   parameter int W              = 8,
   parameter bit RESTORE_BY_ADD = RESTORE_MUX
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dvd_mag,
   input  logic         dvd_sign,
   input  logic [W-1:0] dvs_mag,
   input  logic         dvs_sign,
   output logic [W-1:0] quo_mag,
   output logic [W-1:0] rem_mag,
   output logic         quo_sign,
   output logic         rem_sign,
   output logic         div_zero,
   output logic         done
);
   generate
      if (W < 2) begin : g_bad_width
         $error("smdiv_restoring: W must be at least 2");
      end
   endgenerate

   logic         busy, load, zfin, last;
   logic [W-1:0] a_q, q_q, m_q;
   logic [W-1:0] a_nx, q_nx;
   logic         qs_q, rs_q;

   smdiv_ctrl #(.W(W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .dvs_zero (dvs_mag == '0),
      .busy     (busy),
      .load     (load),
      .zfin     (zfin),
      .last     (last)
   );

   smdiv_step #(.W(W), .RESTORE_BY_ADD(RESTORE_BY_ADD)) u_step (
      .a_i (a_q),
      .q_i (q_q),
      .m_i (m_q),
      .a_o (a_nx),
      .q_o (q_nx)
   );

   // working registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q  <= '0;
         q_q  <= '0;
         m_q  <= '0;
         qs_q <= 1'b0;
         rs_q <= 1'b0;
      end else if (load) begin
         a_q  <= '0;
         q_q  <= dvd_mag;
         m_q  <= dvs_mag;
         qs_q <= dvd_sign ^ dvs_sign;
         rs_q <= dvd_sign;
      end else if (busy) begin
         a_q <= a_nx;
         q_q <= q_nx;
      end
   end

   // result registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_mag  <= '0;
         rem_mag  <= '0;
         quo_sign <= 1'b0;
         rem_sign <= 1'b0;
         div_zero <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= last || zfin;
         if (last) begin
            quo_mag  <= q_nx;
            rem_mag  <= a_nx;
            quo_sign <= qs_q;
            rem_sign <= rs_q;
            div_zero <= 1'b0;
         end else if (zfin) begin
            quo_mag  <= '0;
            rem_mag  <= '0;
            quo_sign <= dvd_sign ^ dvs_sign;
            rem_sign <= dvd_sign;
            div_zero <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/smdiv_restoring_chk.sv
module smdiv_restoring_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [W-1:0] dvd_mag,
   input logic         dvd_sign,
   input logic [W-1:0] dvs_mag,
   input logic         dvs_sign,
   input logic         busy,
   input logic [W-1:0] quo_mag,
   input logic [W-1:0] rem_mag,
   input logic         quo_sign,
   input logic         rem_sign,
   input logic         div_zero,
   input logic         done
);
   localparam int LW = $clog2(W + 2) + 1;
   localparam logic [LW-1:0] LAT = LW'(W + 1);

   logic [W-1:0]  dvd_c, dvs_c;
   logic          ds_c, vs_c;
   logic [LW-1:0] lat_q;
   logic          accept;

   assign accept = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvd_c <= '0;
         dvs_c <= '0;
         ds_c  <= 1'b0;
         vs_c  <= 1'b0;
         lat_q <= '0;
      end else begin
         if (accept) begin
            dvd_c <= dvd_mag;
            dvs_c <= dvs_mag;
            ds_c  <= dvd_sign;
            vs_c  <= dvs_sign;
            lat_q <= (dvs_mag != '0) ? LW'(1) : '0;
         end else if (done) begin
            lat_q <= '0;
         end else if (lat_q != '0) begin
            lat_q <= lat_q + 1'b1;
         end
      end
   end

   p_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_zero) |->
         (({{W{1'b0}}, quo_mag} * {{W{1'b0}}, dvs_c} + {{W{1'b0}}, rem_mag}
           == {{W{1'b0}}, dvd_c}) && (rem_mag < dvs_c)));

   p_qsign_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (quo_sign == (ds_c ^ vs_c)));

   p_rsign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rem_sign == ds_c));

   p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_zero) |-> (quo_mag == '0 && rem_mag == '0 && dvs_c == '0));

   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_zero) |-> (lat_q == LAT));

   p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(quo_mag) && $stable(rem_mag) && $stable(quo_sign)
                 && $stable(rem_sign) && $stable(div_zero)));

endmodule

bind smdiv_restoring smdiv_restoring_chk #(.W(W)) u_chk (.*);

// File: tb/smdiv_restoring_tb.sv
module smdiv_restoring_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] dvd_mag = '0, dvs_mag = '0;
   logic         dvd_sign = 1'b0, dvs_sign = 1'b0;
   logic [W-1:0] quo_mag, rem_mag;
   logic         quo_sign, rem_sign, div_zero, done;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   smdiv_restoring #(.W(W)) u_dut (.*);

   function automatic logic [W-1:0] exp_quo(input logic [W-1:0] n, input logic [W-1:0] d);
      return (d == 0) ? '0 : n / d;
   endfunction

   function automatic logic [W-1:0] exp_rem(input logic [W-1:0] n, input logic [W-1:0] d);
      return (d == 0) ? '0 : n % d;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // run one operation; optionally poke start with other operands mid-run (R7)
   task automatic do_op(input logic [W-1:0] n, input logic ns,
                        input logic [W-1:0] d, input logic ds, input bit poke);
      int cyc;
      logic [W-1:0] hq, hr;
      @(negedge clk);
      dvd_mag = n; dvd_sign = ns; dvs_mag = d; dvs_sign = ds; start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      cyc = 1;
      while (1) begin
         @(negedge clk);
         if (done) break;
         if (poke && cyc == 3) begin
            dvd_mag = ~n; dvs_mag = 8'd1; dvd_sign = ~ns; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(posedge clk);
         cyc++;
         if (cyc > 4 * W) break;
      end
      start = 1'b0;
      if (d == 0) begin
         check("R4 latency", cyc, 1);
         check("R4 div_zero", div_zero, 1);
         check("R4 quo", quo_mag, 0);
         check("R4 rem", rem_mag, 0);
      end else begin
         check(poke ? "R7 latency" : "R5 latency", cyc, W + 1);
         check("R5 div_zero", div_zero, 0);
         check(poke ? "R7 quo" : "R1 quo", quo_mag, exp_quo(n, d));
         check(poke ? "R7 rem" : "R1 rem", rem_mag, exp_rem(n, d));
      end
      check("R2 quo_sign", quo_sign, ns ^ ds);
      check("R3 rem_sign", rem_sign, ns);
      hq = quo_mag; hr = rem_mag;
      @(negedge clk);
      check("R6 done low", done, 0);
      repeat (2) @(negedge clk);
      check("R8 hold quo", quo_mag, hq);
      check("R8 hold rem", rem_mag, hr);
   endtask

   initial begin
      #20000000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] rn, rd;
      logic rs1, rs2;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R9 reset quo", quo_mag, 0);
      check("R9 reset done", done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R9 post quo", quo_mag, 0);
      check("R9 post rem", rem_mag, 0);
      check("R9 post flags", {quo_sign, rem_sign, div_zero, done}, 0);

      do_op(8'd14, 1'b0, 8'd5, 1'b0, 1'b0);     // R1 check value
      do_op(8'd14, 1'b1, 8'd5, 1'b0, 1'b0);     // R2, R3
      do_op(8'd14, 1'b0, 8'd5, 1'b1, 1'b0);
      do_op(8'd14, 1'b1, 8'd5, 1'b1, 1'b0);
      do_op(8'd3, 1'b0, 8'd200, 1'b0, 1'b0);    // R10 small dividend
      do_op(8'd0, 1'b1, 8'd7, 1'b0, 1'b0);      // R10 zero dividend
      do_op(8'd255, 1'b0, 8'd1, 1'b1, 1'b0);    // R10 full scale / 1
      do_op(8'd200, 1'b0, 8'd200, 1'b0, 1'b0);  // R10 equal
      do_op(8'd255, 1'b0, 8'd255, 1'b0, 1'b0);
      do_op(8'd99, 1'b1, 8'd0, 1'b0, 1'b0);     // R4
      do_op(8'd17, 1'b0, 8'd4, 1'b0, 1'b0);     // R4 flag cleared
      do_op(8'd250, 1'b0, 8'd7, 1'b1, 1'b1);    // R7 poke while busy
      for (int i = 0; i < 60; i++) begin
         rn = W'($urandom);
         rd = W'($urandom);
         if (i % 7 == 0) rd = W'($urandom_range(0, 3));
         rs1 = 1'($urandom);
         rs2 = 1'($urandom);
         do_op(rn, rs1, rd, rs2, (i % 11) == 5);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule